// File: doc/BRIEF.md
# PHY Management Register File

This block models the management register set of a Fast Ethernet PHY at the register level. A host selects a target with a PHY address and a register number. It then either reads a 16-bit word on a combinational read port or writes a 16-bit word that takes effect on the next clock edge. The PHY answers only to the address presented on its strap input. Any other address reads as all ones and cannot change anything.

The block holds four live registers: control, status, autonegotiation advertisement and link-partner ability. It also returns two fixed identifier words. A `link_ok` input is sampled on every clock, and it drives the link-status and autonegotiation-complete flags as well as the partner-ability contents. Setting the top bit of control reloads every register default in place of storing the written word. Register numbers follow the usual clause-22 layout: 0 control, 1 status, 2 and 3 identifier, 4 advertisement, 5 partner ability, 6 expansion. Serial framing on the management wire is out of scope, as are real negotiation and the analog path.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, with link down, the registers read: control 0x3100 (bit 13 speed 100, bit 12 autoneg enable, bit 8 full duplex), status 0x7848 (bits 14..11 ability, bit 6 preamble suppression, bit 3 autoneg ability), advertisement 0x01E1, partner ability 0x0080.
- R2: When `phy_addr` differs from `strap_addr`, a read returns 0xFFFF. A write to such an address changes no register.
- R3: One clock after `link_ok` is sampled high, status has bit 2 (link) and bit 5 (autoneg complete) set, reading 0x786C. Partner ability then has bits 8, 6, 5 and 0 ORed in, reading 0x01E1.
- R4: One clock after `link_ok` is sampled low, status bits 2 and 5 are clear (0x7848) and partner ability reads exactly 0x0080.
- R5: A control write with bit 15 clear stores all 16 bits, and the new value is visible from the next cycle.
- R6: A control write with bit 15 set stores nothing of the written word. Instead, control returns to 0x3100, advertisement to 0x01E1, and status and partner ability follow the current `link_ok`.
- R7: The advertisement register (4) stores any written 16-bit word.
- R8: Writes to status (1), the identifier registers (2, 3), partner ability (5) and expansion (6) leave the readable contents unchanged.
- R9: Reads of register 6, of registers 7 to 31, and of any other undefined number return 0.
- R10: Registers 2 and 3 return the parameters `ID_HI` (default 0x0243) and `ID_LO` (default 0x0C54).
- R11: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | AW | This PHY's own management address |
| phy_addr | input | AW | Target PHY address of the access |
| reg_addr | input | AW | Register number of the access |
| rd_en | input | 1 | Read strobe; enables `rd_data` |
| rd_data | output | 16 | Combinational read word |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| wr_data | input | 16 | Write word |
| link_ok | input | 1 | Link state, sampled every clock |

## Verification
A bad control or advertisement bit shows up on the first read of that register after the corrupting edge. Because the reference model is compared on every cycle that reads, such an error is reported within the cycles of the random stretch that follows. A link flag that is stuck or late appears as a status or partner-ability mismatch one cycle after the `link_ok` edge. A broken address match produces 0xFFFF where live data is expected, or the reverse, on the very access that exercises it. A write that leaks into a read-only register is caught when that register is next read.

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs #(
  parameter int          AW    = 5,
  parameter logic [15:0] ID_HI = 16'h0243,
  parameter logic [15:0] ID_LO = 16'h0C54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_addr,
  input  logic [AW-1:0] phy_addr,
  input  logic [AW-1:0] reg_addr,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          link_ok
);

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_IDH  = AW'(2);
  localparam logic [AW-1:0] A_IDL  = AW'(3);
  localparam logic [AW-1:0] A_ADV  = AW'(4);
  localparam logic [AW-1:0] A_LP   = AW'(5);

  localparam logic [15:0] CTRL_DEF  = 16'h3100;
  localparam logic [15:0] STAT_BASE = 16'h7848;
  localparam logic [15:0] STAT_LINK = 16'h0024;
  localparam logic [15:0] ADV_DEF   = 16'h01E1;
  localparam logic [15:0] LP_DOWN   = 16'h0080;
  localparam logic [15:0] LP_UP     = 16'h0161;

  logic [15:0] ctrl, adv, stat, lp;
  logic        hit, wr_ctrl, wr_adv, reload;
  logic [15:0] sel;

  assign hit     = (phy_addr == strap_addr);
  assign wr_ctrl = wr_en && hit && (reg_addr == A_CTRL);
  assign wr_adv  = wr_en && hit && (reg_addr == A_ADV);
  assign reload  = wr_ctrl && wr_data[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_DEF;
      adv  <= ADV_DEF;
      stat <= STAT_BASE;
      lp   <= LP_DOWN;
    end else begin
      if (reload) begin
        ctrl <= CTRL_DEF;
        adv  <= ADV_DEF;
      end else begin
        if (wr_ctrl) ctrl <= wr_data;
        if (wr_adv)  adv  <= wr_data;
      end
      stat <= link_ok ? (STAT_BASE | STAT_LINK) : STAT_BASE;
      if (!link_ok)    lp <= LP_DOWN;
      else if (reload) lp <= LP_DOWN | LP_UP;
      else             lp <= lp | LP_UP;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  sel = ctrl;
      A_STAT:  sel = stat;
      A_IDH:   sel = ID_HI;
      A_IDL:   sel = ID_LO;
      A_ADV:   sel = adv;
      A_LP:    sel = lp;
      default: sel = 16'h0000;
    endcase
  end

  assign rd_data = !rd_en ? 16'h0000 : (hit ? sel : 16'hFFFF);

  AST_LINK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat[2] == $past(link_ok)) && (stat[5] == $past(link_ok))); // R3
  AST_LP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> lp == 16'h0080); // R4
  AST_LP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok |=> (lp & 16'h0161) == 16'h0161); // R3
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(ctrl) && $stable(adv)); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit && reg_addr == A_CTRL) |=> $stable(ctrl)); // R5
  AST_ADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit && (reg_addr == A_ADV || reg_addr == A_CTRL)) |=> $stable(adv)); // R7
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && reg_addr == A_CTRL && wr_data[15]) |=> ctrl == 16'h3100 && adv == 16'h01E1); // R6

endmodule

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
  localparam int AW = 5;
  localparam logic [AW-1:0] ME = 5'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] strap_addr = ME;
  logic [AW-1:0] phy_addr = '0;
  logic [AW-1:0] reg_addr = '0;
  logic          rd_en = 1'b0;
  logic [15:0]   rd_data;
  logic          wr_en = 1'b0;
  logic [15:0]   wr_data = '0;
  logic          link_ok = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_ctrl = 'h3100, m_adv = 'h01E1, m_stat = 'h7848, m_lp = 'h0080;

  always #10 clk = ~clk;

  phy_mgmt_regs u_phy_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .phy_addr(phy_addr),
    .reg_addr(reg_addr), .rd_en(rd_en), .rd_data(rd_data), .wr_en(wr_en),
    .wr_data(wr_data), .link_ok(link_ok)
  );

  function automatic int m_read();
    if (!rd_en) return 0;
    if (phy_addr != strap_addr) return 'hFFFF;
    case (int'(reg_addr))
      0: return m_ctrl;
      1: return m_stat;
      2: return 'h0243;
      3: return 'h0C54;
      4: return m_adv;
      5: return m_lp;
      default: return 0;
    endcase
  endfunction

  function automatic void m_step();
    bit h = (phy_addr == strap_addr);
    bit rl = wr_en && h && reg_addr == 0 && wr_data[15];
    if (rl) begin m_ctrl = 'h3100; m_adv = 'h01E1; end
    else begin
      if (wr_en && h && reg_addr == 0) m_ctrl = int'(wr_data);
      if (wr_en && h && reg_addr == 4) m_adv = int'(wr_data);
    end
    m_stat = link_ok ? 'h786C : 'h7848;
    if (!link_ok) m_lp = 'h0080;
    else m_lp = (rl ? 'h0080 : m_lp) | 'h0161;
  endfunction

  task automatic check(input string tag);
    int exp = m_read();
    checks++;
    if (int'(rd_data) != exp) begin
      errors++;
      $display("FAIL %s: pa=%0d ra=%0d rd_data=%h expected=%h", tag, phy_addr, reg_addr, rd_data, exp[15:0]);
    end
  endtask

  task automatic cyc(input logic [AW-1:0] pa, input logic [AW-1:0] ra, input bit rd,
                     input bit wr, input logic [15:0] wd, input bit lk, input string tag);
    phy_addr = pa; reg_addr = ra; rd_en = rd; wr_en = wr; wr_data = wd; link_ok = lk;
    #1;
    check(tag);
    @(posedge clk);
    m_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset values read while reset is held
    for (int r = 0; r < 6; r++) begin
      phy_addr = ME; reg_addr = AW'(r); rd_en = 1'b1; #1; check("R1");
    end
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    cyc(ME, 0, 1, 0, 0, 0, "R1");
    cyc(ME, 1, 1, 0, 0, 0, "R1");
    cyc(ME, 5, 1, 0, 0, 0, "R1");
    // R10 identifiers
    cyc(ME, 2, 1, 0, 0, 0, "R10");
    cyc(ME, 3, 1, 0, 0, 0, "R10");
    // R11 idle read port
    cyc(ME, 0, 0, 0, 0, 0, "R11");
    cyc(5'd9, 2, 0, 0, 0, 0, "R11");
    // R3 link up
    cyc(ME, 1, 1, 0, 0, 1, "R3");
    cyc(ME, 1, 1, 0, 0, 1, "R3");
    cyc(ME, 5, 1, 0, 0, 1, "R3");
    // R4 link down
    cyc(ME, 5, 1, 0, 0, 0, "R4");
    cyc(ME, 5, 1, 0, 0, 0, "R4");
    cyc(ME, 1, 1, 0, 0, 0, "R4");
    // R5 control store
    cyc(ME, 0, 0, 1, 16'h0A5A, 0, "R5");
    cyc(ME, 0, 1, 0, 0, 0, "R5");
    // R7 advertisement store
    cyc(ME, 4, 0, 1, 16'hBEEF, 1, "R7");
    cyc(ME, 4, 1, 0, 0, 1, "R7");
    // R2 mismatched address: read all ones, write ignored
    cyc(5'd7, 0, 1, 0, 0, 1, "R2");
    cyc(5'd7, 0, 0, 1, 16'h1234, 1, "R2");
    cyc(5'd7, 4, 0, 1, 16'h5678, 1, "R2");
    cyc(ME, 0, 1, 0, 0, 1, "R2");
    cyc(ME, 4, 1, 0, 0, 1, "R2");
    // R8 read-only writes
    cyc(ME, 1, 0, 1, 16'h0000, 1, "R8");
    cyc(ME, 1, 1, 0, 0, 1, "R8");
    cyc(ME, 2, 0, 1, 16'hFFFF, 1, "R8");
    cyc(ME, 2, 1, 0, 0, 1, "R8");
    cyc(ME, 5, 0, 1, 16'h0000, 1, "R8");
    cyc(ME, 5, 1, 0, 0, 1, "R8");
    cyc(ME, 6, 0, 1, 16'hFFFF, 1, "R8");
    cyc(ME, 6, 1, 0, 0, 1, "R8");
    // R9 undefined registers read zero
    for (int r = 6; r < 32; r++) cyc(ME, AW'(r), 1, 0, 0, 1, "R9");
    // R6 reload via control bit 15, link up then down
    cyc(ME, 0, 0, 1, 16'h8000, 1, "R6");
    cyc(ME, 0, 1, 0, 0, 1, "R6");
    cyc(ME, 4, 1, 0, 0, 1, "R6");
    cyc(ME, 5, 1, 0, 0, 1, "R6");
    cyc(ME, 4, 0, 1, 16'h0021, 0, "R6");
    cyc(ME, 0, 0, 1, 16'hFFFF, 0, "R6");
    cyc(ME, 0, 1, 0, 0, 0, "R6");
    cyc(ME, 4, 1, 0, 0, 0, "R6");
    cyc(ME, 1, 1, 0, 0, 0, "R6");
    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pa = ($urandom_range(0, 3) == 0) ? AW'($urandom) : ME;
      logic [AW-1:0] ra = AW'($urandom_range(0, 7));
      bit wr = ($urandom_range(0, 2) == 0);
      logic [15:0] wd = 16'($urandom);
      if ($urandom_range(0, 3) != 0) wd[15] = 1'b0;
      cyc(pa, ra, $urandom_range(0, 5) != 0, wr, wd, $urandom_range(0, 7) != 0, "R5");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule